// File: doc/BRIEF.md
# Supervised Clock Rate Guard

This block watches a clock of unknown health, called the supervised clock, from a free-running reference clock. It reports an error when the supervised clock runs too slowly or has stopped. The error also covers a clock that never starts after reset. The supervised clock passes through a multi-stage synchronizer into the reference domain. Its rising edges are counted over fixed reference windows of `3 * REF_HZ / MIN_HZ` cycles. A window that closes with fewer than `MIN_EDGES` (2) counted edges marks the clock as failed.

The error drives an active-low fault line that is shared with a watchdog. The block outputs the AND of the watchdog's own active-low output and the monitor's active-low output. After a failure, the first window with enough edges clears the raw error flag. The fault line is then still held low for `REL_CYC` further reference cycles before it is released. `REL_CYC` is a parameter restricted to 16..32.

Monitoring is controlled by an enable taken from the watchdog's write-once configuration register. That register bit reads 1 as reset ends, so detection is live from the first window after reset. While reset is asserted, the monitor has no effect on the fault line.

Top module: `clkrate_guard`

## Requirements
- R1: While `rst_n` is low, `slow_o` is 0 and `fault_n` equals `wdog_n`.
- R2: A supervised clock whose period is at most one third of the window (at or above the minimum rate) never raises `slow_o` once any earlier error has been released.
- R3: While the supervised clock stays below the minimum rate, `slow_o` stays 1 and `fault_n` stays 0 in every cycle.
- R4: With `mon_en` high and the supervised clock stopped, `slow_o` is 1 no later than 2 windows plus 8 reference cycles after reset ends, after the clock stops, or after `mon_en` rises. The error persists for as long as the clock stays stopped.
- R5: With `mon_en` and `wdog_n` high, `fault_n` rises exactly `REL_CYC` reference cycles after `slow_o` falls. A window with too few edges during that delay returns the block to error. `REL_CYC` must lie in 16..32.
- R6: While `mon_en` is 0, `slow_o` is 0 and `fault_n` equals `wdog_n` in the same cycle, whatever the supervised clock does.
- R7: `fault_n` is 0 whenever `wdog_n` is 0.
- R8: After a supervised clock that was running correctly stops, `slow_o` rises and `fault_n` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; all state is clocked by it |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_clk | input | 1 | Supervised clock, asynchronous to `ref_clk` |
| mon_en | input | 1 | Monitor enable from the watchdog's write-once register (1 after reset) |
| wdog_n | input | 1 | Watchdog output, active low |
| slow_o | output | 1 | Raw error flag: supervised clock judged too slow or stopped |
| fault_n | output | 1 | Shared active-low fault line: `wdog_n` AND the monitor's active-low output |

## Verification
The assertions assume that the supervised clock's period is at least four reference cycles. Under that condition every rising edge survives the synchronizer as a separate pulse, so the capped edge counter and the window evaluation can be trusted. The bench only drives periods of 8, 20 and 200 reference cycles, or a stopped clock. It places the supervised clock's transitions halfway between reference edges, so no sample lands on an ambiguous instant. `mon_en` and `wdog_n` change only on falling reference edges, which keeps them synchronous inputs as the properties expect.

// File: rtl/clkrate_guard_pkg.sv
package clkrate_guard_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_FAULT = 2'd1,
      ST_HOLD  = 2'd2
   } guard_state_e;

   localparam int unsigned REL_CYC_LO = 16;
   localparam int unsigned REL_CYC_HI = 32;

endpackage

// File: rtl/clkrate_sync.sv
module clkrate_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] ff_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("clkrate_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff_q[0] <= 1'b0;
               else        ff_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff_q[i] <= 1'b0;
               else        ff_q[i] <= ff_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/clkrate_window.sv
module clkrate_window #(
   parameter int WIN_LEN   = 60,
   parameter int MIN_EDGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   output logic done_o,
   output logic ok_o
);
   localparam int CW = $clog2(WIN_LEN);
   localparam int EW = $clog2(MIN_EDGES + 1);

   generate
      if (WIN_LEN < 2) begin : g_bad_win
         $error("clkrate_window: WIN_LEN must be at least 2");
      end
      if (MIN_EDGES < 1) begin : g_bad_min
         $error("clkrate_window: MIN_EDGES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] tick_q;
   logic [EW-1:0] seen_q;
   logic          last;
   logic [EW:0]   total;

   assign last  = (tick_q == CW'(WIN_LEN - 1));
   assign total = {1'b0, seen_q} + (EW+1)'(edge_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         seen_q <= '0;
         done_o <= 1'b0;
         ok_o   <= 1'b0;
      end else begin
         tick_q <= last ? '0 : tick_q + 1'b1;
         done_o <= last;
         if (last) begin
            ok_o   <= (total >= (EW+1)'(MIN_EDGES));
            seen_q <= '0;
         end else if (edge_i && (seen_q != EW'(MIN_EDGES))) begin
            seen_q <= seen_q + 1'b1;
         end
      end
   end

   // R2: the edge count saturates and never runs past the threshold
   p_seen_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q <= EW'(MIN_EDGES));

   // R4: window closes are isolated single-cycle events
   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/clkrate_release.sv
module clkrate_release
   import clkrate_guard_pkg::*;
#(
   parameter int REL_CYC = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic win_done_i,
   input  logic win_ok_i,
   output logic slow_o,
   output logic hold_low_o
);
   localparam int CW = $clog2(REL_CYC + 1);

   generate
      if (REL_CYC < REL_CYC_LO || REL_CYC > REL_CYC_HI) begin : g_bad_rel
         $error("clkrate_release: REL_CYC must lie in 16..32");
      end
   endgenerate

   guard_state_e  state_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         cnt_q   <= '0;
      end else if (!en_i) begin
         state_q <= ST_RUN;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_RUN: begin
               if (win_done_i && !win_ok_i) state_q <= ST_FAULT;
            end
            ST_FAULT: begin
               if (win_done_i && win_ok_i) begin
                  state_q <= ST_HOLD;
                  cnt_q   <= '0;
               end
            end
            ST_HOLD: begin
               if (win_done_i && !win_ok_i) begin
                  state_q <= ST_FAULT;
               end else if (cnt_q == CW'(REL_CYC - 1)) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign slow_o     = (state_q == ST_FAULT);
   assign hold_low_o = (state_q != ST_RUN);

   // R3: the error state is entered only after a window with too few edges
   p_enter_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FAULT && $past(state_q) != ST_FAULT)
         |-> $past(en_i && win_done_i && !win_ok_i));

   // R5: the hold phase ends only once the full delay has been counted
   p_release_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && $past(state_q) == ST_HOLD && $past(en_i))
         |-> $past(cnt_q) == CW'(REL_CYC - 1));
endmodule

// File: rtl/clkrate_guard.sv
module clkrate_guard #(
   parameter int REF_HZ      = 1_000_000,
   parameter int MIN_HZ      = 25_000,
   parameter int MIN_EDGES   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int REL_CYC     = 24
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic mon_clk,
   input  logic mon_en,
   input  logic wdog_n,
   output logic slow_o,
   output logic fault_n
);
   localparam int WIN_LEN = (3 * REF_HZ) / MIN_HZ;

   generate
      if (MIN_HZ * 4 > REF_HZ) begin : g_bad_ratio
         $error("clkrate_guard: reference must be at least 4x the minimum rate");
      end
      if (WIN_LEN < 8) begin : g_bad_window
         $error("clkrate_guard: window shorter than 8 reference cycles");
      end
   endgenerate

   logic mon_s;
   logic mon_prev_q;
   logic edge_p;
   logic win_done;
   logic win_ok;
   logic st_slow;
   logic st_hold;

   clkrate_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d_i   (mon_clk),
      .q_o   (mon_s)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) mon_prev_q <= 1'b0;
      else        mon_prev_q <= mon_s;
   end
   assign edge_p = mon_s & ~mon_prev_q;

   clkrate_window #(.WIN_LEN(WIN_LEN), .MIN_EDGES(MIN_EDGES)) u_window (
      .clk    (ref_clk),
      .rst_n  (rst_n),
      .edge_i (edge_p),
      .done_o (win_done),
      .ok_o   (win_ok)
   );

   clkrate_release #(.REL_CYC(REL_CYC)) u_release (
      .clk        (ref_clk),
      .rst_n      (rst_n),
      .en_i       (mon_en),
      .win_done_i (win_done),
      .win_ok_i   (win_ok),
      .slow_o     (st_slow),
      .hold_low_o (st_hold)
   );

   assign slow_o  = mon_en & st_slow;
   assign fault_n = wdog_n & ~(mon_en & st_hold);

   // R1: monitor is inert during reset
   always @(posedge ref_clk) begin
      if (!rst_n) begin
         p_reset_inert_r1: assert (fault_n == wdog_n && !slow_o);
      end
   end

   // R6: disabled monitor leaves the shared line to the watchdog
   p_disable_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !mon_en |-> (fault_n == wdog_n && !slow_o));

   // R7: a watchdog fault always reaches the shared line
   p_wdog_and_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !wdog_n |-> !fault_n);

   // R3: a raw error always holds the shared line low
   p_err_low_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      slow_o |-> !fault_n);
endmodule

// File: tb/clkrate_guard_tb_top.sv
`timescale 1ns/100ps
module clkrate_guard_tb_top;
   localparam int REF_HZ  = 1_000_000;
   localparam int MIN_HZ  = 50_000;
   localparam int REL_CYC = 24;
   localparam int WIN     = (3 * REF_HZ) / MIN_HZ;
   localparam int DET_MAX = 2 * WIN + 8;

   logic ref_clk = 1'b0;
   logic rst_n   = 1'b0;
   logic mon_clk = 1'b0;
   logic mon_en  = 1'b1;
   logic wdog_n  = 1'b1;
   logic slow_o;
   logic fault_n;

   int mon_half = 0;
   int total = 0;
   int bad   = 0;

   always #2.5 ref_clk = ~ref_clk;

   initial begin
      forever begin
         if (mon_half == 0) begin
            mon_clk = 1'b0;
            #5;
         end else begin
            #(mon_half) mon_clk = ~mon_clk;
         end
      end
   end

   clkrate_guard #(
      .REF_HZ(REF_HZ), .MIN_HZ(MIN_HZ), .MIN_EDGES(2),
      .SYNC_STAGES(2), .REL_CYC(REL_CYC)
   ) dut_i (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .mon_clk (mon_clk),
      .mon_en  (mon_en),
      .wdog_n  (wdog_n),
      .slow_o  (slow_o),
      .fault_n (fault_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge ref_clk);
   endtask

   // cycles until slow_o is seen high, capped
   task automatic wait_slow(output int n);
      n = 0;
      while (!slow_o && n < 4 * WIN) begin
         @(negedge ref_clk);
         n++;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      wdog_n = 1'b1;
      cyc(3);
      chk(fault_n == 1'b1 && slow_o == 1'b0, "R1 reset wdog high", {slow_o, fault_n}, 1);
      wdog_n = 1'b0;
      cyc(1);
      chk(fault_n == 1'b0 && slow_o == 1'b0, "R1 reset wdog low", {slow_o, fault_n}, 0);
      wdog_n = 1'b1;
      cyc(1);
   endtask

   task automatic t_dead_start();
      int n;
      int lows;
      mon_half = 0;
      rst_n = 1'b1;
      wait_slow(n);
      chk(slow_o && n <= DET_MAX, "R4 dead start detect", n, DET_MAX);
      lows = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge ref_clk);
         if (!fault_n && slow_o) lows++;
      end
      chk(lows == 300, "R4 dead start persists", lows, 300);
   endtask

   task automatic t_recover_release();
      int k;
      int waited;
      mon_half = 20;                    // 8 reference cycles per period
      waited = 0;
      while (slow_o && waited < 4 * WIN) begin
         @(negedge ref_clk);
         waited++;
      end
      chk(!slow_o && !fault_n, "R5 error clears, line held", {slow_o, fault_n}, 0);
      k = 0;
      while (!fault_n && k < 100) begin
         @(negedge ref_clk);
         k++;
      end
      chk(k == REL_CYC, "R5 release delay", k, REL_CYC);
   endtask

   task automatic t_min_rate();
      int hits;
      mon_half = 50;                    // 20 reference cycles: the minimum rate
      hits = 0;
      for (int i = 0; i < 10 * WIN; i++) begin
         @(negedge ref_clk);
         if (slow_o || !fault_n) hits++;
      end
      chk(hits == 0, "R2 minimum rate never flagged", hits, 0);
   endtask

   task automatic t_slow();
      int n;
      int lows;
      mon_half = 500;                   // 200 reference cycles per period
      wait_slow(n);
      chk(slow_o == 1'b1, "R3 slow clock detected", slow_o, 1);
      lows = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge ref_clk);
         if (slow_o && !fault_n) lows++;
      end
      chk(lows == 600, "R3 slow clock held low", lows, 600);
   endtask

   task automatic t_stop_midrun();
      int n;
      mon_half = 20;
      cyc(4 * WIN + REL_CYC);
      chk(fault_n && !slow_o, "R8 running before stop", {slow_o, fault_n}, 1);
      mon_half = 0;
      wait_slow(n);
      chk(slow_o && n <= DET_MAX, "R8 stop detected", n, DET_MAX);
      cyc(1);
      chk(!fault_n, "R8 line low after stop", fault_n, 0);
   endtask

   task automatic t_disable();
      int n;
      mon_en = 1'b0;
      cyc(1);
      chk(!slow_o && fault_n, "R6 disable releases line", {slow_o, fault_n}, 1);
      cyc(3 * WIN);
      chk(!slow_o && fault_n, "R6 dead clock ignored", {slow_o, fault_n}, 1);
      wdog_n = 1'b0;
      cyc(1);
      chk(!fault_n, "R7 watchdog drives line", fault_n, 0);
      wdog_n = 1'b1;
      cyc(1);
      chk(fault_n, "R7 watchdog release", fault_n, 1);
      mon_en = 1'b1;
      wait_slow(n);
      chk(slow_o && n <= DET_MAX, "R4 re-enable detect", n, DET_MAX);
   endtask

   task automatic t_wdog_and_running();
      mon_half = 20;
      cyc(4 * WIN + REL_CYC);
      chk(fault_n, "R5 recovered after re-enable", fault_n, 1);
      wdog_n = 1'b0;
      cyc(1);
      chk(!fault_n, "R7 AND with healthy clock", fault_n, 0);
      wdog_n = 1'b1;
      cyc(1);
   endtask

   initial begin
      cyc(200_000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200_000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_dead_start();
      t_recover_release();
      t_min_rate();
      t_slow();
      t_recover_release();
      t_stop_midrun();
      t_disable();
      t_wdog_and_running();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule